// File: doc/BRIEF.md
# Two-Pass Multiply-Accumulate Unit

This block is the multiply side of a 32-bit integer core. It has a single array that multiplies a full-width `rs` by a half-width slice of `rt`. The unit looks at `rt` to decide how much work an operation needs. If `rt` fits in the half width, the product is formed in one pass. Otherwise the low half of `rt` goes through the array first. The high half follows on the next cycle, and its partial product is shifted up by the half width and added to the first one.

A finished 64-bit product goes to one of two places. It can load, add to or subtract from the HI:LO accumulator pair. It can also leave the unit as a register-file write of its low word. The unit runs its own pipeline and has no stall input from the integer pipeline.

The integer pipeline sees three interfaces:
- an issue port with a ready output that holds back a request while the array finishes a second pass;
- a register-file write port;
- a HI/LO read port that waits while an accumulator update is still in flight.

Top module: `mac_unit`

## Requirements
- R1: After reset, `iss_ready` is 1, `gpr_wen` is 0 and both accumulator words read as zero.
- R2: The unit reads the signed/unsigned choice from bit 0 of `iss_op` (0 = signed). A signed operation is one-pass when `rt[31:15]` are all equal. An unsigned operation is one-pass when `rt[31:16]` is zero. Every other operation takes two passes.
- R3: A one-pass operation does not lower `iss_ready`, so one-pass operations can be accepted on consecutive cycles. Its accumulator result is visible after the second rising edge counted from the edge that accepted it.
- R4: `iss_ready` is 0 for exactly the one cycle after a two-pass operation is accepted. A request held during that cycle is accepted on the following edge. A two-pass result appears one edge later than a one-pass result.
- R5: Code 0 (signed) and code 1 (unsigned) load HI:LO with the 64-bit product. HI holds bits 63:32.
- R6: Code 2 (signed) and code 3 (unsigned) add the product to HI:LO, modulo 2^64.
- R7: Code 4 (signed) and code 5 (unsigned) subtract the product from HI:LO, modulo 2^64.
- R8: Code 6 forms a signed product and leaves HI:LO unchanged. `gpr_wen` is 1 for one cycle with `gpr_wdata` equal to the product's low 32 bits, and it appears in the cycle where a code 0–5 operation would have updated HI:LO.
- R9: `mf_ready` is 0 from the edge that accepts a code 0–5 operation until HI:LO holds that operation's result. Code 6 does not lower `mf_ready`.
- R10: `mf_data` returns HI when `mf_sel_hi` is 1 and LO when it is 0, but only while both `mf_valid` and `mf_ready` are 1. At any other time it is zero.
- R11: Code 7 is consumed without effect. It does not stall the unit, does not write the register file and leaves HI:LO unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request present |
| iss_op | input | 3 | Operation code (R5–R8, R11) |
| iss_rs | input | 32 | Full-width multiplicand |
| iss_rt | input | 32 | Multiplier, examined for pass count |
| iss_ready | output | 1 | Unit can take a request this cycle |
| gpr_wen | output | 1 | Register-file write strobe |
| gpr_wdata | output | 32 | Low product word for the register file |
| mf_valid | input | 1 | Accumulator read request |
| mf_sel_hi | input | 1 | 1 selects HI, 0 selects LO |
| mf_ready | output | 1 | Accumulator result is current |
| mf_data | output | 32 | Selected accumulator word |

## Verification
All six accumulator codes are swept over operand sets built around the points where the operand size changes. These include values one step on either side of the 16-bit signed and unsigned limits, zero and one, and the most negative and all-ones words. The sweep separates one-pass from two-pass products and shows whether signed and unsigned extension were applied correctly. It also shows whether each product was loaded, added or subtracted.

Directed sequences look at behaviour that a final result cannot reveal. They check which cycle `iss_ready` and `mf_ready` drop, and that held and back-to-back requests are not lost. They confirm that a register-file product leaves HI:LO alone and that the idle code has no effect.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [2:0] {
    MOP_SET_S = 3'd0,
    MOP_SET_U = 3'd1,
    MOP_ADD_S = 3'd2,
    MOP_ADD_U = 3'd3,
    MOP_SUB_S = 3'd4,
    MOP_SUB_U = 3'd5,
    MOP_REG   = 3'd6,
    MOP_IDLE  = 3'd7
  } mac_op_e;

  typedef enum logic [2:0] {
    ACC_NONE = 3'd0,
    ACC_LOAD = 3'd1,
    ACC_ADD  = 3'd2,
    ACC_SUB  = 3'd3,
    ACC_GPR  = 3'd4
  } acc_kind_e;

  // Even codes carry signed operands; the idle code is odd and unsigned.
  function automatic logic op_is_signed(logic [2:0] op);
    return (op != MOP_IDLE) && !op[0];
  endfunction

  // Does the operation change the HI:LO pair once it retires?
  function automatic logic op_hits_hilo(logic [2:0] op);
    return (op != MOP_REG) && (op != MOP_IDLE);
  endfunction

  function automatic acc_kind_e op_kind(logic [2:0] op);
    case (op)
      MOP_SET_S, MOP_SET_U: return ACC_LOAD;
      MOP_ADD_S, MOP_ADD_U: return ACC_ADD;
      MOP_SUB_S, MOP_SUB_U: return ACC_SUB;
      MOP_REG:              return ACC_GPR;
      default:              return ACC_NONE;
    endcase
  endfunction

endpackage

// File: rtl/mac_sizer.sv
module mac_sizer #(
  parameter int XLEN = 32,
  localparam int HALF = XLEN / 2
) (
  input  logic [XLEN-1:0] rt,
  input  logic            is_signed,
  output logic            narrow
);

  // The upper part is redundant when it is pure sign (signed) or pure zero (unsigned).
  function automatic logic fits_half(logic [XLEN-1:0] v, logic sgn);
    logic [XLEN-HALF:0] top_s;
    logic [XLEN-HALF-1:0] top_u;
    top_s = v[XLEN-1:HALF-1];
    top_u = v[XLEN-1:HALF];
    if (sgn)
      return (top_s == '0) || (top_s == '1);
    return top_u == '0;
  endfunction

  assign narrow = fits_half(rt, is_signed);

endmodule

// File: rtl/mac_array.sv
module mac_array #(
  parameter int XLEN = 32,
  localparam int HALF = XLEN / 2,
  localparam int PRODW = 2 * XLEN
) (
  input  logic [XLEN-1:0]  a,
  input  logic             a_sgn,
  input  logic [HALF-1:0]  b,
  input  logic             b_sgn,
  output logic [PRODW-1:0] prod
);

  // Full-width by half-width pass; both operands extended to the product width,
  // so the truncated product is the exact two's-complement result.
  function automatic logic [PRODW-1:0] pass_mul(
    logic [XLEN-1:0] x, logic xs, logic [HALF-1:0] y, logic ys);
    logic [PRODW-1:0] xe;
    logic [PRODW-1:0] ye;
    xe = {{(PRODW-XLEN){xs & x[XLEN-1]}}, x};
    ye = {{(PRODW-HALF){ys & y[HALF-1]}}, y};
    return xe * ye;
  endfunction

  assign prod = pass_mul(a, a_sgn, b, b_sgn);

endmodule

// File: rtl/mac_seq.sv
module mac_seq
  import mac_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int HALF = XLEN / 2,
  localparam int PRODW = 2 * XLEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic [2:0]       iss_op,
  input  logic [XLEN-1:0]  iss_rs,
  input  logic [XLEN-1:0]  iss_rt,
  input  logic             rt_narrow,
  input  logic [PRODW-1:0] arr_prod,
  output logic [XLEN-1:0]  arr_a,
  output logic             arr_a_sgn,
  output logic [HALF-1:0]  arr_b,
  output logic             arr_b_sgn,
  output logic             iss_ready,
  output logic             accept,
  output logic             accept_wide,
  output logic             pp_valid,
  output logic [2:0]       pp_op,
  output logic [PRODW-1:0] pp_q,
  output logic             hilo_busy
);

  logic            p2_q;
  logic [XLEN-1:0] h_rs;
  logic [HALF-1:0] h_rt_hi;
  logic [2:0]      h_op;
  logic            h_sgn;
  logic            iss_sgn;

  // Upper-half partial product weighs 2^HALF relative to the first pass.
  function automatic logic [PRODW-1:0] merge_upper(
    logic [PRODW-1:0] lo_pp, logic [PRODW-1:0] hi_pp);
    return lo_pp + (hi_pp << HALF);
  endfunction

  assign iss_sgn     = op_is_signed(iss_op);
  assign iss_ready   = !p2_q;
  assign accept      = iss_valid && iss_ready && (iss_op != MOP_IDLE);
  assign accept_wide = accept && !rt_narrow;
  assign hilo_busy   = (p2_q && op_hits_hilo(h_op)) ||
                       (pp_valid && op_hits_hilo(pp_op));

  always_comb begin
    if (p2_q) begin
      arr_a     = h_rs;
      arr_a_sgn = h_sgn;
      arr_b     = h_rt_hi;
      arr_b_sgn = h_sgn;
    end else begin
      arr_a     = iss_rs;
      arr_a_sgn = iss_sgn;
      arr_b     = iss_rt[HALF-1:0];
      arr_b_sgn = iss_sgn && rt_narrow;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p2_q     <= 1'b0;
      h_rs     <= '0;
      h_rt_hi  <= '0;
      h_op     <= MOP_IDLE;
      h_sgn    <= 1'b0;
      pp_valid <= 1'b0;
      pp_op    <= MOP_IDLE;
      pp_q     <= '0;
    end else begin
      pp_valid <= 1'b0;
      if (p2_q) begin
        pp_q     <= merge_upper(pp_q, arr_prod);
        pp_valid <= 1'b1;
        pp_op    <= h_op;
        p2_q     <= 1'b0;
      end else if (accept) begin
        pp_q <= arr_prod;
        if (rt_narrow) begin
          pp_valid <= 1'b1;
          pp_op    <= iss_op;
        end else begin
          p2_q    <= 1'b1;
          h_rs    <= iss_rs;
          h_rt_hi <= iss_rt[XLEN-1:HALF];
          h_op    <= iss_op;
          h_sgn   <= iss_sgn;
        end
      end
    end
  end

endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int PRODW = 2 * XLEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pp_valid,
  input  logic [2:0]       pp_op,
  input  logic [PRODW-1:0] pp_q,
  input  logic             hilo_busy,
  input  logic             mf_valid,
  input  logic             mf_sel_hi,
  output logic             mf_ready,
  output logic [XLEN-1:0]  mf_data,
  output logic             gpr_wen,
  output logic [XLEN-1:0]  gpr_wdata
);

  logic [PRODW-1:0] hilo_q;

  function automatic logic [PRODW-1:0] acc_next(
    acc_kind_e k, logic [PRODW-1:0] acc, logic [PRODW-1:0] p);
    case (k)
      ACC_LOAD: return p;
      ACC_ADD:  return acc + p;
      ACC_SUB:  return acc - p;
      default:  return acc;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] pick_word(logic [PRODW-1:0] acc, logic hi);
    return hi ? acc[PRODW-1:XLEN] : acc[XLEN-1:0];
  endfunction

  assign mf_ready = !hilo_busy;
  assign mf_data  = (mf_valid && mf_ready) ? pick_word(hilo_q, mf_sel_hi) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hilo_q    <= '0;
      gpr_wen   <= 1'b0;
      gpr_wdata <= '0;
    end else begin
      gpr_wen <= 1'b0;
      if (pp_valid) begin
        if (op_kind(pp_op) == ACC_GPR) begin
          gpr_wen   <= 1'b1;
          gpr_wdata <= pp_q[XLEN-1:0];
        end else begin
          hilo_q <= acc_next(op_kind(pp_op), hilo_q, pp_q);
        end
      end
    end
  end

endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int HALF = XLEN / 2,
  localparam int PRODW = 2 * XLEN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_valid,
  input  logic [2:0]      iss_op,
  input  logic [XLEN-1:0] iss_rs,
  input  logic [XLEN-1:0] iss_rt,
  output logic            iss_ready,
  output logic            gpr_wen,
  output logic [XLEN-1:0] gpr_wdata,
  input  logic            mf_valid,
  input  logic            mf_sel_hi,
  output logic            mf_ready,
  output logic [XLEN-1:0] mf_data
);

  logic             rt_narrow;
  logic [XLEN-1:0]  arr_a;
  logic             arr_a_sgn;
  logic [HALF-1:0]  arr_b;
  logic             arr_b_sgn;
  logic [PRODW-1:0] arr_prod;
  logic             ev_accept;
  logic             ev_accept_wide;
  logic             pp_valid;
  logic [2:0]       pp_op;
  logic [PRODW-1:0] pp_q;
  logic             ev_hilo_busy;

  mac_sizer #(.XLEN(XLEN)) u_sizer (
    .rt        (iss_rt),
    .is_signed (op_is_signed(iss_op)),
    .narrow    (rt_narrow)
  );

  mac_array #(.XLEN(XLEN)) u_array (
    .a     (arr_a),
    .a_sgn (arr_a_sgn),
    .b     (arr_b),
    .b_sgn (arr_b_sgn),
    .prod  (arr_prod)
  );

  mac_seq #(.XLEN(XLEN)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .iss_valid   (iss_valid),
    .iss_op      (iss_op),
    .iss_rs      (iss_rs),
    .iss_rt      (iss_rt),
    .rt_narrow   (rt_narrow),
    .arr_prod    (arr_prod),
    .arr_a       (arr_a),
    .arr_a_sgn   (arr_a_sgn),
    .arr_b       (arr_b),
    .arr_b_sgn   (arr_b_sgn),
    .iss_ready   (iss_ready),
    .accept      (ev_accept),
    .accept_wide (ev_accept_wide),
    .pp_valid    (pp_valid),
    .pp_op       (pp_op),
    .pp_q        (pp_q),
    .hilo_busy   (ev_hilo_busy)
  );

  mac_accum #(.XLEN(XLEN)) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .pp_valid  (pp_valid),
    .pp_op     (pp_op),
    .pp_q      (pp_q),
    .hilo_busy (ev_hilo_busy),
    .mf_valid  (mf_valid),
    .mf_sel_hi (mf_sel_hi),
    .mf_ready  (mf_ready),
    .mf_data   (mf_data),
    .gpr_wen   (gpr_wen),
    .gpr_wdata (gpr_wdata)
  );

endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk
  import mac_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       iss_valid,
  input logic [2:0] iss_op,
  input logic       iss_ready,
  input logic       mf_ready,
  input logic       gpr_wen,
  input logic       ev_accept,
  input logic       ev_accept_wide
);

  p_wide_blocks_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept_wide |=> !iss_ready);

  p_stall_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_ready |=> iss_ready);

  p_narrow_keeps_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && !ev_accept_wide) |=> iss_ready);

  p_read_waits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && (iss_op != MOP_REG)) |=> !mf_ready);

  p_reg_write_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && !ev_accept_wide && (iss_op == MOP_REG)) |=> ##1 gpr_wen);

  p_idle_no_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && (iss_op == MOP_IDLE)) |=> (iss_ready && mf_ready));

endmodule

bind mac_unit mac_unit_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .iss_valid      (iss_valid),
  .iss_op         (iss_op),
  .iss_ready      (iss_ready),
  .mf_ready       (mf_ready),
  .gpr_wen        (gpr_wen),
  .ev_accept      (ev_accept),
  .ev_accept_wide (ev_accept_wide)
);

// File: tb/mac_unit_tb.sv
module mac_unit_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic [2:0]  iss_op = 3'd7;
  logic [31:0] iss_rs = '0;
  logic [31:0] iss_rt = '0;
  logic        iss_ready;
  logic        gpr_wen;
  logic [31:0] gpr_wdata;
  logic        mf_valid = 1'b0;
  logic        mf_sel_hi = 1'b0;
  logic        mf_ready;
  logic [31:0] mf_data;

  int n_vec = 0;
  int n_bad = 0;
  logic [63:0] model = '0;
  logic [63:0] got;

  logic [31:0] rs_set [8] = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h7FFFFFFF,
                              32'h80000000, 32'h12345678, 32'hFFFF8000, 32'h0000FFFF};
  logic [31:0] rt_set [10] = '{32'h0, 32'h3, 32'h7FFF, 32'h8000, 32'hFFFF,
                               32'h10000, 32'hFFFF8000, 32'hFFFF7FFF, 32'h80000000, 32'hDEADBEEF};

  always #(CLK_P/2) clk = ~clk;

  mac_unit u_dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_rs(iss_rs), .iss_rt(iss_rt), .iss_ready(iss_ready),
    .gpr_wen(gpr_wen), .gpr_wdata(gpr_wdata), .mf_valid(mf_valid),
    .mf_sel_hi(mf_sel_hi), .mf_ready(mf_ready), .mf_data(mf_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference: signed codes are even; sign extension done through 64-bit integers.
  function automatic logic [63:0] ref_prod(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    longint sa, sb;
    if (!op[0]) begin
      sa = longint'(signed'(a));
      sb = longint'(signed'(b));
      return sa * sb;
    end
    return {32'h0, a} * {32'h0, b};
  endfunction

  function automatic logic [63:0] ref_acc(logic [2:0] op, logic [63:0] acc, logic [63:0] p);
    case (op)
      3'd0, 3'd1: return p;
      3'd2, 3'd3: return acc + p;
      3'd4, 3'd5: return acc - p;
      default:    return acc;
    endcase
  endfunction

  task automatic send(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    iss_valid = 1'b1; iss_op = op; iss_rs = a; iss_rt = b;
    while (!iss_ready) @(negedge clk);
    @(posedge clk);
    #1 iss_valid = 1'b0;
  endtask

  task automatic read_hilo(output logic [63:0] v);
    int guard;
    guard = 0;
    @(negedge clk);
    mf_valid = 1'b1;
    while (!mf_ready && guard < 10) begin
      @(negedge clk);
      guard++;
    end
    mf_sel_hi = 1'b0;
    #1 v[31:0] = mf_data;
    mf_sel_hi = 1'b1;
    #1 v[63:32] = mf_data;
    mf_valid = 1'b0;
    mf_sel_hi = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk("R1 iss_ready", iss_ready, 1);
    chk("R1 gpr_wen", gpr_wen, 0);
    read_hilo(got);
    chk("R1 hilo", got, 0);

    // R3 R5 R9 R10: one-pass signed load, cycle by cycle
    send(3'd0, 32'd5, 32'd7);
    model = 64'd35;
    @(negedge clk);
    chk("R3 ready after narrow", iss_ready, 1);
    chk("R9 read blocked", mf_ready, 0);
    mf_valid = 1'b1;
    #1 chk("R10 data zero while busy", mf_data, 0);
    mf_valid = 1'b0;
    @(negedge clk);
    chk("R9 read free", mf_ready, 1);
    read_hilo(got);
    chk("R5 narrow load", got, model);
    mf_valid = 1'b0; mf_sel_hi = 1'b0;
    #1 chk("R10 data zero without request", mf_data, 0);

    // R2 R4: two-pass unsigned load timing
    send(3'd1, 32'd3, 32'h10000);
    model = 64'h30000;
    @(negedge clk);
    chk("R4 stall after wide", iss_ready, 0);
    chk("R9 blocked pass2", mf_ready, 0);
    @(negedge clk);
    chk("R4 ready again", iss_ready, 1);
    chk("R4 result not yet", mf_ready, 0);
    @(negedge clk);
    chk("R4 result ready", mf_ready, 1);
    read_hilo(got);
    chk("R4 wide load", got, model);

    // R2: size boundaries seen through the stall
    begin
      logic [2:0]  b_op [8] = '{3'd0, 3'd0, 3'd0, 3'd1, 3'd1, 3'd0, 3'd1, 3'd0};
      logic [31:0] b_rt [8] = '{32'hFFFF8000, 32'hFFFF7FFF, 32'h00008000, 32'h00008000,
                                32'h00010000, 32'h00007FFF, 32'hFFFFFFFF, 32'hFFFFFFFF};
      logic        b_wd [8] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
      for (int i = 0; i < 8; i++) begin
        send(b_op[i], 32'd1, b_rt[i]);
        @(negedge clk);
        chk($sformatf("R2 size rt=%h op=%0d", b_rt[i], b_op[i]), iss_ready, !b_wd[i]);
        repeat (2) @(negedge clk);
      end
      model = ref_prod(3'd0, 32'd1, 32'hFFFFFFFF);
    end

    // R4 R6: back-to-back wide requests, second held through the stall
    send(3'd0, 32'd1, 32'd0);
    @(negedge clk);
    iss_valid = 1'b1; iss_op = 3'd3; iss_rs = 32'd2; iss_rt = 32'h20000;
    @(posedge clk);
    #1 begin iss_op = 3'd3; iss_rs = 32'd3; iss_rt = 32'h30000; end
    @(negedge clk);
    chk("R4 held request stalled", iss_ready, 0);
    @(negedge clk);
    chk("R4 held request ready", iss_ready, 1);
    @(posedge clk);
    #1 iss_valid = 1'b0;
    read_hilo(got);
    chk("R4 R6 back-to-back wide sum", got, 64'hD0000);

    // R3 R7: one-pass subtracts on consecutive cycles
    send(3'd0, 32'd100, 32'd1);
    @(negedge clk);
    iss_valid = 1'b1; iss_op = 3'd4; iss_rs = 32'd10; iss_rt = 32'd2;
    @(posedge clk);
    #1 begin iss_op = 3'd4; iss_rs = 32'd5; iss_rt = 32'd3; end
    @(negedge clk);
    chk("R3 consecutive ready", iss_ready, 1);
    @(posedge clk);
    #1 begin iss_op = 3'd5; iss_rs = 32'd1; iss_rt = 32'd1; end
    @(posedge clk);
    #1 iss_valid = 1'b0;
    model = 64'd64;
    read_hilo(got);
    chk("R3 R7 consecutive subtract", got, model);

    // R8 R9: register-file product
    send(3'd6, 32'hFFFFFFFF, 32'd7);
    @(negedge clk);
    chk("R8 no early write", gpr_wen, 0);
    chk("R9 not blocked by reg op", mf_ready, 1);
    @(negedge clk);
    chk("R8 write strobe", gpr_wen, 1);
    chk("R8 write data", gpr_wdata, 32'hFFFFFFF9);
    @(negedge clk);
    chk("R8 single pulse", gpr_wen, 0);
    read_hilo(got);
    chk("R8 hilo untouched", got, model);

    // R11: idle code
    send(3'd7, 32'd9, 32'h12340000);
    @(negedge clk);
    chk("R11 no stall", iss_ready, 1);
    chk("R11 no write", gpr_wen, 0);
    @(negedge clk);
    chk("R11 no write later", gpr_wen, 0);
    read_hilo(got);
    chk("R11 hilo untouched", got, model);

    // R5 R6 R7: sweep all accumulator codes over boundary operands
    for (int op = 0; op < 6; op++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 10; j++) begin
          send(3'(op), rs_set[i], rt_set[j]);
          model = ref_acc(3'(op), model, ref_prod(3'(op), rs_set[i], rt_set[j]));
          read_hilo(got);
          chk($sformatf("R5 R6 R7 sweep op=%0d rs=%h rt=%h", op, rs_set[i], rt_set[j]),
              got, model);
        end
      end
    end

    // R8: sweep register-file products
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 10; j++) begin
        logic [31:0] seen;
        logic [63:0] p;
        seen = 32'hXXXXXXXX;
        p = ref_prod(3'd6, rs_set[i], rt_set[j]);
        send(3'd6, rs_set[i], rt_set[j]);
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          if (gpr_wen) seen = gpr_wdata;
        end
        chk($sformatf("R8 sweep rs=%h rt=%h", rs_set[i], rt_set[j]), seen, p[31:0]);
      end
    end
    read_hilo(got);
    chk("R8 hilo after reg sweep", got, model);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule